// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the interrupt causes of a UART and condenses them into the identification word a host reads. The causes are receive line errors, receive FIFO fill, a character time-out, transmit holding register empty, modem line changes and two auto-baud events. It holds the per-cause enable register, the FIFO enable and the receive trigger-level setting. It keeps sticky latches for the causes that arrive as pulses. Each cycle it selects the most urgent enabled cause and reports it as a 3-bit code under an active-low pending bit.

The receive FIFO is not part of the block; its occupancy arrives as a count. The transmit and receive datapaths, the baud generator and the auto-baud engine sit beside it and deliver single-cycle event pulses and level signals. Because nothing streams through the block, all pins are plain control and status signals with no valid/ready handshake. A read strobe on the identification word acknowledges a transmit-empty cause that the word is reporting. Separate read strobes for the line-status and modem-status registers clear their latches.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0 and the identification word reads 10'h001: nothing pending, code 0, FIFO-enable mirror 0, auto-baud flags 0.
- R2: A write to the enable register keeps only bits 0 (receive data), 1 (transmit empty), 2 (line status), 3 (modem status), 7 (CTS change), 8 (auto-baud end) and 9 (auto-baud time-out). Bits 4 to 6 always read 0, so writing 10'h3FF reads back 10'h38F.
- R3: Bit 0 of the identification word is 0 while at least one enabled cause, auto-baud flags included, is pending, and 1 otherwise.
- R4: Bits 3:1 carry the winning cause. The codes are 3 for line status, 2 for receive data, 6 for character time-out, 1 for transmit empty and 0 for modem status, and they win in that order. When no coded cause is pending the field is 0, and when nothing at all is pending bits 9:8 are also 0.
- R5: With the FIFO enabled, trigger select values 0, 1, 2 and 3 give receive thresholds of 1, 4, 8 and 14 characters. With the FIFO disabled the threshold is 1. Receive data is pending exactly while the count is at or above the threshold, and it drops in the same cycle the count falls below it.
- R6: Bits 7 and 6 of the identification word both equal the registered FIFO-enable bit. Bits 5:4 are 0.
- R7: An overrun, parity, framing or break pulse sets a sticky line-status cause that is visible the cycle after the pulse. A line-status read clears it. A new error in the same cycle as the read wins.
- R8: A time-out strobe sets a sticky time-out cause, gated by enable bit 0, that is visible the next cycle. A change of the receive count clears it.
- R9: A rising edge of the transmit-empty input sets the transmit-empty cause. A read of the identification word while it shows code 1 clears the cause, and a falling edge of the input also clears it.
- R10: A modem-change pulse (gated by bit 3) or a CTS-change pulse (gated by bit 7) sets its own sticky latch, reported as code 0. A modem-status read clears both latches.
- R11: The auto-baud end and time-out pulses set sticky flags shown in bits 8 and 9 when bits 8 and 9 of the enable register are set. Clear bits 0 and 1 remove them, write-one-to-clear style, and a set pulse wins over a clear in the same cycle.
- R12: Clearing an enable bit hides its cause without discarding the latch, so setting the bit again reports the cause once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 10 | Enable register write value |
| fifo_cfg_wr | input | 1 | Write strobe for FIFO enable and trigger select |
| fifo_cfg_en | input | 1 | FIFO enable value to write |
| fifo_cfg_trig | input | 2 | Trigger select value to write |
| rx_count | input | COUNT_W | Current receive FIFO occupancy |
| err_overrun | input | 1 | Overrun error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| lsr_rd | input | 1 | Line-status read strobe |
| char_timeout | input | 1 | Character time-out strobe |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_delta | input | 1 | Modem status change pulse |
| cts_delta | input | 1 | CTS transition pulse |
| msr_rd | input | 1 | Modem-status read strobe |
| ab_end_set | input | 1 | Auto-baud completion pulse |
| ab_tmo_set | input | 1 | Auto-baud time-out pulse |
| ab_clr | input | 2 | Write-one-to-clear for the auto-baud flags (bit 0 end, bit 1 time-out) |
| id_rd | input | 1 | Identification word read strobe |
| en_q | output | 10 | Enable register contents |
| irq_id | output | 10 | Identification word |

## Verification
The properties assume that event inputs are single-cycle pulses and that the enable register is not rewritten in the same cycle as the events they check. They also assume that the read strobe for the identification word is sampled in the same cycle as the code it acknowledges. The stimulus drives every pulse for exactly one clock on the falling edge. It holds the enable and FIFO configuration steady around each event, and it changes the receive count only where a time-out latch should clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int EN_W = 10;

  // enable bit positions, also used for the auto-baud flag positions in the id word
  localparam int EN_RDA  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_RLS  = 2;
  localparam int EN_MS   = 3;
  localparam int EN_CTS  = 7;
  localparam int EN_ABE  = 8;
  localparam int EN_ABT  = 9;

  localparam logic [EN_W-1:0] EN_MASK =
    EN_W'((1 << EN_RDA) | (1 << EN_THRE) | (1 << EN_RLS) | (1 << EN_MS) |
          (1 << EN_CTS) | (1 << EN_ABE) | (1 << EN_ABT));

  typedef enum logic [2:0] {
    CODE_MODEM = 3'd0,
    CODE_THRE  = 3'd1,
    CODE_RDA   = 3'd2,
    CODE_RLS   = 3'd3,
    CODE_CTI   = 3'd6
  } irq_code_e;

  typedef struct packed {
    logic rls;
    logic rda;
    logic cti;
    logic thre;
    logic ms;
    logic cts;
    logic abe;
    logic abt;
  } irq_raw_t;

endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
  import uart_irq_pkg::*;
#(
  parameter int COUNT_W = 5,
  parameter int LVL0    = 1,
  parameter int LVL1    = 4,
  parameter int LVL2    = 8,
  parameter int LVL3    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [EN_W-1:0]    en_wdata,
  input  logic               fifo_cfg_wr,
  input  logic               fifo_cfg_en,
  input  logic [1:0]         fifo_cfg_trig,
  output logic [EN_W-1:0]    en_q,
  output logic               fifo_en_q,
  output logic [COUNT_W-1:0] thresh
);

  localparam logic [COUNT_W-1:0] T0 = COUNT_W'(LVL0);
  localparam logic [COUNT_W-1:0] T1 = COUNT_W'(LVL1);
  localparam logic [COUNT_W-1:0] T2 = COUNT_W'(LVL2);
  localparam logic [COUNT_W-1:0] T3 = COUNT_W'(LVL3);

  logic [1:0] trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      fifo_en_q <= 1'b0;
      trig_q    <= 2'd0;
    end else begin
      if (en_wr) en_q <= en_wdata & EN_MASK;
      if (fifo_cfg_wr) begin
        fifo_en_q <= fifo_cfg_en;
        trig_q    <= fifo_cfg_trig;
      end
    end
  end

  always_comb begin
    if (!fifo_en_q) begin
      thresh = COUNT_W'(1);
    end else begin
      unique case (trig_q)
        2'd0:    thresh = T0;
        2'd1:    thresh = T1;
        2'd2:    thresh = T2;
        default: thresh = T3;
      endcase
    end
  end

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int COUNT_W = 5,
  parameter int N_ERR   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] rx_count,
  input  logic [COUNT_W-1:0] thresh,
  input  logic [N_ERR-1:0]   err_in,
  input  logic               lsr_rd,
  input  logic               char_timeout,
  input  logic               thr_empty,
  input  logic               thre_ack,
  input  logic               modem_delta,
  input  logic               cts_delta,
  input  logic               msr_rd,
  input  logic               ab_end_set,
  input  logic               ab_tmo_set,
  input  logic [1:0]         ab_clr,
  output irq_raw_t           raw
);

  logic [N_ERR-1:0]   err_q;
  logic [COUNT_W-1:0] cnt_prev;
  logic               thr_prev;
  logic               cti_q, thre_q, ms_q, cts_q, abe_q, abt_q;

  // one sticky latch per error kind; a new error beats the clearing read
  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n)         err_q[i] <= 1'b0;
      else if (err_in[i]) err_q[i] <= 1'b1;
      else if (lsr_rd)    err_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_prev <= '0;
      thr_prev <= 1'b1;
      cti_q    <= 1'b0;
      thre_q   <= 1'b0;
      ms_q     <= 1'b0;
      cts_q    <= 1'b0;
      abe_q    <= 1'b0;
      abt_q    <= 1'b0;
    end else begin
      cnt_prev <= rx_count;
      thr_prev <= thr_empty;

      if (char_timeout)               cti_q <= 1'b1;
      else if (rx_count != cnt_prev)  cti_q <= 1'b0;

      if (thr_empty && !thr_prev)     thre_q <= 1'b1;
      else if (thre_ack || !thr_empty) thre_q <= 1'b0;

      if (modem_delta)  ms_q <= 1'b1;
      else if (msr_rd)  ms_q <= 1'b0;

      if (cts_delta)    cts_q <= 1'b1;
      else if (msr_rd)  cts_q <= 1'b0;

      if (ab_end_set)     abe_q <= 1'b1;
      else if (ab_clr[0]) abe_q <= 1'b0;

      if (ab_tmo_set)     abt_q <= 1'b1;
      else if (ab_clr[1]) abt_q <= 1'b0;
    end
  end

  always_comb begin
    raw.rls  = |err_q;
    raw.rda  = (rx_count >= thresh);
    raw.cti  = cti_q;
    raw.thre = thre_q;
    raw.ms   = ms_q;
    raw.cts  = cts_q;
    raw.abe  = abe_q;
    raw.abt  = abt_q;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_raw_t        raw,
  input  logic [EN_W-1:0] en_q,
  input  logic            fifo_en_q,
  output logic [9:0]      irq_id,
  output logic            thre_shown
);

  logic rls_v, rda_v, cti_v, thre_v, ms_v, abe_v, abt_v;
  logic any_coded, pending;
  irq_code_e code;

  always_comb begin
    rls_v  = raw.rls  & en_q[EN_RLS];
    rda_v  = raw.rda  & en_q[EN_RDA];
    cti_v  = raw.cti  & en_q[EN_RDA];
    thre_v = raw.thre & en_q[EN_THRE];
    ms_v   = (raw.ms & en_q[EN_MS]) | (raw.cts & en_q[EN_CTS]);
    abe_v  = raw.abe  & en_q[EN_ABE];
    abt_v  = raw.abt  & en_q[EN_ABT];

    any_coded = rls_v | rda_v | cti_v | thre_v | ms_v;
    pending   = any_coded | abe_v | abt_v;

    if (rls_v)       code = CODE_RLS;
    else if (rda_v)  code = CODE_RDA;
    else if (cti_v)  code = CODE_CTI;
    else if (thre_v) code = CODE_THRE;
    else             code = CODE_MODEM;

    thre_shown = pending && (code == CODE_THRE);
    irq_id = {abt_v, abe_v, {2{fifo_en_q}}, 2'b00, code, ~pending};
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int COUNT_W = 5,
  parameter int LVL0    = 1,
  parameter int LVL1    = 4,
  parameter int LVL2    = 8,
  parameter int LVL3    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [9:0]         en_wdata,
  input  logic               fifo_cfg_wr,
  input  logic               fifo_cfg_en,
  input  logic [1:0]         fifo_cfg_trig,
  input  logic [COUNT_W-1:0] rx_count,
  input  logic               err_overrun,
  input  logic               err_parity,
  input  logic               err_framing,
  input  logic               err_break,
  input  logic               lsr_rd,
  input  logic               char_timeout,
  input  logic               thr_empty,
  input  logic               modem_delta,
  input  logic               cts_delta,
  input  logic               msr_rd,
  input  logic               ab_end_set,
  input  logic               ab_tmo_set,
  input  logic [1:0]         ab_clr,
  input  logic               id_rd,
  output logic [9:0]         en_q,
  output logic [9:0]         irq_id
);

  logic               fifo_en_q;
  logic [COUNT_W-1:0] thresh;
  irq_raw_t           raw;
  logic               thre_shown;
  logic               thre_ack;

  assign thre_ack = id_rd & thre_shown;

  uart_irq_cfg #(
    .COUNT_W(COUNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .fifo_cfg_wr(fifo_cfg_wr), .fifo_cfg_en(fifo_cfg_en),
    .fifo_cfg_trig(fifo_cfg_trig),
    .en_q(en_q), .fifo_en_q(fifo_en_q), .thresh(thresh)
  );

  uart_irq_src #(.COUNT_W(COUNT_W), .N_ERR(4)) u_src (
    .clk(clk), .rst_n(rst_n),
    .rx_count(rx_count), .thresh(thresh),
    .err_in({err_break, err_framing, err_parity, err_overrun}),
    .lsr_rd(lsr_rd), .char_timeout(char_timeout),
    .thr_empty(thr_empty), .thre_ack(thre_ack),
    .modem_delta(modem_delta), .cts_delta(cts_delta), .msr_rd(msr_rd),
    .ab_end_set(ab_end_set), .ab_tmo_set(ab_tmo_set), .ab_clr(ab_clr),
    .raw(raw)
  );

  uart_irq_prio u_prio (
    .raw(raw), .en_q(en_q), .fifo_en_q(fifo_en_q),
    .irq_id(irq_id), .thre_shown(thre_shown)
  );

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int COUNT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_wr,
  input logic [COUNT_W-1:0] rx_count,
  input logic               err_overrun,
  input logic               err_parity,
  input logic               err_framing,
  input logic               err_break,
  input logic               thr_empty,
  input logic               ab_end_set,
  input logic [1:0]         ab_clr,
  input logic               id_rd,
  input logic [9:0]         en_q,
  input logic [9:0]         irq_id
);

  // R7
  rls_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_overrun | err_parity | err_framing | err_break) && en_q[2] && !en_wr)
      |=> (irq_id[3:1] == 3'd3 && !irq_id[0]));

  // R5
  rda_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_id[0] && irq_id[3:1] == 3'd2) |-> (rx_count != '0));

  // R4
  idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id[0] |-> (irq_id[3:1] == 3'd0 && irq_id[9:8] == 2'b00));

  // R9
  thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && !irq_id[0] && irq_id[3:1] == 3'd1 && !$rose(thr_empty))
      |=> (irq_id[3:1] != 3'd1));

  // R11
  abe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_end_set && en_q[8] && !en_wr) |=> (irq_id[8] && !irq_id[0]));

  // R11
  abe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_clr[0] && !ab_end_set) |=> !irq_id[8]);

  // R6
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id[7] == irq_id[6]) && (irq_id[5:4] == 2'b00));

endmodule

bind uart_irq_ident uart_irq_chk #(.COUNT_W(COUNT_W)) u_chk (.*);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_wr = 1'b0;
  logic [9:0]    en_wdata = '0;
  logic          fifo_cfg_wr = 1'b0;
  logic          fifo_cfg_en = 1'b0;
  logic [1:0]    fifo_cfg_trig = '0;
  logic [CW-1:0] rx_count = '0;
  logic          err_overrun = 1'b0, err_parity = 1'b0;
  logic          err_framing = 1'b0, err_break = 1'b0;
  logic          lsr_rd = 1'b0, char_timeout = 1'b0, thr_empty = 1'b0;
  logic          modem_delta = 1'b0, cts_delta = 1'b0, msr_rd = 1'b0;
  logic          ab_end_set = 1'b0, ab_tmo_set = 1'b0;
  logic [1:0]    ab_clr = '0;
  logic          id_rd = 1'b0;
  logic [9:0]    en_q, irq_id;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.COUNT_W(CW)) u0 (.*);

  // ier, fifo_en, trig, count, expected id word
  typedef struct packed {
    logic [9:0]    ier;
    logic          fen;
    logic [1:0]    trig;
    logic [CW-1:0] cnt;
    logic [9:0]    exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{10'h001, 1'b1, 2'd0, 5'd1,  10'h0C4},
    '{10'h001, 1'b1, 2'd0, 5'd0,  10'h0C1},
    '{10'h001, 1'b1, 2'd1, 5'd3,  10'h0C1},
    '{10'h001, 1'b1, 2'd1, 5'd4,  10'h0C4},
    '{10'h001, 1'b1, 2'd2, 5'd7,  10'h0C1},
    '{10'h001, 1'b1, 2'd2, 5'd8,  10'h0C4},
    '{10'h001, 1'b1, 2'd3, 5'd13, 10'h0C1},
    '{10'h001, 1'b1, 2'd3, 5'd14, 10'h0C4},
    '{10'h001, 1'b1, 2'd3, 5'd16, 10'h0C4},
    '{10'h001, 1'b0, 2'd3, 5'd1,  10'h004},
    '{10'h001, 1'b0, 2'd3, 5'd0,  10'h001},
    '{10'h000, 1'b1, 2'd0, 5'd5,  10'h0C1}
  };

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic set_en(logic [9:0] v);
    en_wr = 1'b1; en_wdata = v;
    step();
    en_wr = 1'b0;
  endtask

  task automatic set_fifo(logic e, logic [1:0] t);
    fifo_cfg_wr = 1'b1; fifo_cfg_en = e; fifo_cfg_trig = t;
    step();
    fifo_cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 en", en_q, 10'h000);
    check("R1 id", irq_id, 10'h001);

    // R2 reserved enable bits
    set_en(10'h3FF);
    check("R2 en", en_q, 10'h38F);

    // table walk: R3 R5 R6 R12 on the receive threshold
    foreach (VECS[i]) begin
      en_wr = 1'b1; en_wdata = VECS[i].ier;
      fifo_cfg_wr = 1'b1; fifo_cfg_en = VECS[i].fen; fifo_cfg_trig = VECS[i].trig;
      rx_count = VECS[i].cnt;
      step();
      en_wr = 1'b0; fifo_cfg_wr = 1'b0;
      check($sformatf("R5 vec%0d", i), irq_id, VECS[i].exp);
    end

    // R7 and R4: line status over receive data
    set_en(10'h3FF);
    set_fifo(1'b1, 2'd0);
    rx_count = 5'd2;
    step();
    check("R4 rda", irq_id, 10'h0C4);
    err_parity = 1'b1; step(); err_parity = 1'b0;
    check("R7 rls", irq_id, 10'h0C6);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    check("R7 cleared", irq_id, 10'h0C4);
    err_break = 1'b1; lsr_rd = 1'b1; step(); err_break = 1'b0; lsr_rd = 1'b0;
    check("R7 set wins", irq_id, 10'h0C6);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;

    // R8 time-out below threshold
    set_fifo(1'b1, 2'd1);
    rx_count = 5'd1;
    step();
    check("R8 idle", irq_id, 10'h0C1);
    char_timeout = 1'b1; step(); char_timeout = 1'b0;
    check("R8 cti", irq_id, 10'h0CC);
    step();
    check("R8 sticky", irq_id, 10'h0CC);
    rx_count = 5'd2; step();
    check("R8 cleared", irq_id, 10'h0C1);

    // R9 transmit empty
    rx_count = 5'd0; step();
    thr_empty = 1'b1; step();
    check("R9 thre", irq_id, 10'h0C2);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    check("R9 ack", irq_id, 10'h0C1);
    thr_empty = 1'b0; step();
    thr_empty = 1'b1; step();
    check("R9 reset", irq_id, 10'h0C2);

    // R4 transmit empty over modem, R10 modem
    modem_delta = 1'b1; step(); modem_delta = 1'b0;
    check("R4 thre>ms", irq_id, 10'h0C2);
    thr_empty = 1'b0; step();
    check("R10 modem", irq_id, 10'h0C0);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    check("R10 cleared", irq_id, 10'h0C1);
    set_en(10'h080);
    cts_delta = 1'b1; step(); cts_delta = 1'b0;
    check("R10 cts", irq_id, 10'h0C0);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    check("R10 cts clr", irq_id, 10'h0C1);

    // R11 auto-baud flags
    set_en(10'h3FF);
    ab_end_set = 1'b1; step(); ab_end_set = 1'b0;
    check("R11 end", irq_id, 10'h1C0);
    ab_tmo_set = 1'b1; step(); ab_tmo_set = 1'b0;
    check("R11 both", irq_id, 10'h3C0);
    ab_clr = 2'b01; step(); ab_clr = 2'b00;
    check("R11 clr end", irq_id, 10'h2C0);
    ab_tmo_set = 1'b1; ab_clr = 2'b10; step(); ab_tmo_set = 1'b0; ab_clr = 2'b00;
    check("R11 set wins", irq_id, 10'h2C0);
    ab_clr = 2'b10; step(); ab_clr = 2'b00;
    check("R11 clr tmo", irq_id, 10'h0C1);

    // R12 masking keeps the latch; R3 bit 0 follows enabled causes only
    ab_end_set = 1'b1; step(); ab_end_set = 1'b0;
    set_en(10'h000);
    check("R12 hidden", irq_id, 10'h0C1);
    set_en(10'h100);
    check("R12 shown", irq_id, 10'h1C0);
    check("R3 abe pend", {9'd0, irq_id[0]}, 10'h000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule